// File: doc/BRIEF.md
# Three-Wire Serial Gain Register Port

This block is the slave end of a half-duplex serial control link. The link has one data wire, and the direction of that wire reverses partway through a frame. The host lowers an active-low select line and clocks out 24 bits, most significant first: a direction flag, a 15-bit register address, and one data byte. A single address is decoded. A write to that address loads an 8-bit holding register. A read from it returns the stored byte on the shared data wire during the byte phase of the frame.

The holding register drives a downstream gain controller through two level outputs. The low six bits are a gain code, where 0 means maximum gain. The top two bits choose the size of an extra attenuation step that a separate fast-reduction input can apply. These outputs are plain levels that hold their value until the next write. They have no handshake and take no back-pressure.

All serial inputs are resampled into the system clock through a synchronizer chain, and the block detects clock edges in that domain. The data wire is split into an input, an output and an output enable, so an on-chip pad can combine them.

Top module: `spi3_gain_port`

## Requirements
- R1: After reset the register holds 0x00, so `gain_code` is 0 and `fa_step` is 0, and `spi_sdo_oe` is low.
- R2: A frame starts when `spi_csn` falls. Bits are taken on rising edges of `spi_sclk` in this order: the direction bit, then address bits 14 down to 0, then data bits 7 down to 0. Each high phase and each low phase of the serial clock must last at least SYNC_STAGES+3 system clock cycles.
- R3: A write frame (direction bit 0) to address 0x100 loads the register once the 24th bit is taken. Data bits 5..0 appear on `gain_code` and data bits 7..6 appear on `fa_step`.
- R4: A write frame to any other address leaves the register unchanged.
- R5: A read frame (direction bit 1) to address 0x100 returns the stored byte on `spi_sdo`, most significant bit first. Each bit changes after a falling edge of the serial clock and is valid at the next rising edge.
- R6: A read frame to any other address returns 0x00 during the byte phase.
- R7: `spi_sdo_oe` is high only in a read frame. It rises after the falling edge that follows the 16th rising edge and falls after the falling edge that follows the 24th rising edge. It is low during the header, throughout a write, and whenever `spi_csn` is high.
- R8: If `spi_csn` rises before the 24th bit is taken, the frame is abandoned and the register does not change.
- R9: Clock edges that arrive after the 24th bit and before `spi_csn` rises are ignored. They change neither the register nor the data wire.
- R10: Raising `spi_csn` always resets the frame logic, so the next falling edge starts a clean frame even after an abandoned one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Data wire, input side |
| spi_sdo | output | 1 | Data wire, output side |
| spi_sdo_oe | output | 1 | Output enable for the data wire |
| gain_code | output | 6 | Gain code, 0 = maximum gain |
| fa_step | output | 2 | Fast-reduction step select |

## Verification
The bench writes every one of the 256 byte values to the live address and checks the two output fields. This shows whether the data bits are split into the right fields and taken in the right order. It reads back a spread of values, which separates correct bit-serial return and enable timing from a fixed or shifted output. The address is then moved by one bit at a time across all 15 address positions. Writes and reads at those addresses show whether every address bit takes part in the decode. Frames cut short at every length from 1 to 23 bits, and frames padded with extra clock pulses, show whether commit happens exactly on the 24th bit.

// File: rtl/spi3_gain_pkg.sv
package spi3_gain_pkg;
  localparam int GAIN_W = 6;
  localparam int STEP_W = 2;
  localparam int WORD_W = GAIN_W + STEP_W;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [GAIN_W-1:0] gain;
  } gain_word_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame #(
  parameter int                ADDR_W   = 15,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h100,
  parameter int                DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] reg_value,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int HDR_LEN   = 1 + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [HDR_LEN-1:0] sh_q;
  logic [HDR_LEN-1:0] sh_nxt;
  logic [DATA_W-1:0]  tx_q;
  logic               rd_q;
  logic               hit_q;
  logic               hdr_last;
  logic               data_last;
  logic               addr_hit;

  // Shift register view including the bit arriving on this edge
  assign sh_nxt    = {sh_q[HDR_LEN-2:0], sdi_s};
  assign addr_hit  = (sh_nxt[ADDR_W-1:0] == REG_ADDR);
  assign hdr_last  = !csn_s && sclk_rise && (cnt_q == CNT_W'(HDR_LEN - 1));
  assign data_last = !csn_s && sclk_rise && (cnt_q == CNT_W'(FRAME_LEN - 1));

  assign wr_stb  = data_last && !rd_q && hit_q;
  assign wr_data = sh_nxt[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      rd_q   <= 1'b0;
      hit_q  <= 1'b0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (csn_s) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      hit_q  <= 1'b0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      if (sclk_rise && cnt_q != CNT_W'(FRAME_LEN)) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= sh_nxt;
      end
      if (hdr_last) begin
        rd_q  <= sh_nxt[HDR_LEN-1];
        hit_q <= addr_hit;
        tx_q  <= addr_hit ? reg_value : '0;
      end
      if (sclk_fall) begin
        if (cnt_q == CNT_W'(HDR_LEN) && rd_q) begin
          sdo_oe <= 1'b1;
          sdo    <= tx_q[DATA_W-1];
          tx_q   <= tx_q << 1;
        end else if (sdo_oe && cnt_q > CNT_W'(HDR_LEN) && cnt_q < CNT_W'(FRAME_LEN)) begin
          sdo  <= tx_q[DATA_W-1];
          tx_q <= tx_q << 1;
        end else if (cnt_q == CNT_W'(FRAME_LEN)) begin
          sdo_oe <= 1'b0;
          sdo    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi3_gain_reg.sv
module spi3_gain_reg
  import spi3_gain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  gain_word_t wr_data,
  output gain_word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_stb) q <= wr_data;
  end
endmodule

// File: rtl/spi3_gain_port.sv
module spi3_gain_port
  import spi3_gain_pkg::*;
#(
  parameter int                ADDR_W      = 15,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 'h100,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [GAIN_W-1:0] gain_code,
  output logic [STEP_W-1:0] fa_step
);
  logic       csn_s, sclk_s, sdi_s, sclk_d;
  logic       sclk_rise, sclk_fall;
  logic       wr_stb;
  gain_word_t wr_data;
  gain_word_t reg_q;

  spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_csn, spi_sclk, spi_sdi}),
    .q    ({csn_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  spi3_frame #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DATA_W(WORD_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .sdi_s    (sdi_s),
    .reg_value(reg_q),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .sdo      (spi_sdo),
    .sdo_oe   (spi_sdo_oe)
  );

  spi3_gain_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .q      (reg_q)
  );

  assign gain_code = reg_q.gain;
  assign fa_step   = reg_q.step;
endmodule

// File: rtl/spi3_gain_port_chk.sv
module spi3_gain_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_s,
  input logic       sclk_s,
  input logic       sdo,
  input logic       sdo_oe,
  input logic [5:0] gain_code,
  input logic [1:0] fa_step
);
  AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) (csn_s && $past(csn_s)) |-> !sdo_oe); // R7
  AST_REG_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !$stable({fa_step, gain_code}) |-> !$past(csn_s)); // R8
  AST_OE_RISE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe) |-> !sclk_s); // R5
  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sdo_oe && $past(sdo_oe) && sclk_s) |-> $stable(sdo)); // R5
endmodule

bind spi3_gain_port spi3_gain_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn_s    (csn_s),
  .sclk_s   (sclk_s),
  .sdo      (spi_sdo),
  .sdo_oe   (spi_sdo_oe),
  .gain_code(gain_code),
  .fa_step  (fa_step)
);

// File: tb/sim_spi3_gain_port.sv
`timescale 1ns/1ps
module sim_spi3_gain_port;
  localparam int HALF = 5;
  localparam logic [14:0] LIVE = 15'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [5:0] gain;
  logic [1:0] step;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  spi3_gain_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_csn   (csn),
    .spi_sclk  (sclk),
    .spi_sdi   (sdi),
    .spi_sdo   (sdo),
    .spi_sdo_oe(sdo_oe),
    .gain_code (gain),
    .fa_step   (step)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // One frame of nbits clocks; bits past 24 come from junk.
  task automatic xfer(input bit rd, input logic [14:0] addr, input logic [7:0] dat,
                      input logic [7:0] junk, input int nbits,
                      output logic [7:0] got, output int oe_bad);
    logic [31:0] vec;
    bit exp_oe;
    vec = {rd, addr, dat, junk};
    got = '0;
    oe_bad = 0;
    @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i <= nbits; i++) begin
      if (i < nbits) sdi = vec[31-i];
      repeat (HALF) @(negedge clk);
      exp_oe = rd && (i >= 16) && (i < 24);
      if (sdo_oe !== exp_oe) oe_bad++;
      if (exp_oe) got[23-i] = sdo;
      if (i < nbits) begin
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
    end
    csn = 1'b1;
    sdi = 1'b0;
    repeat (8) @(negedge clk);
    if (sdo_oe !== 1'b0) oe_bad++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({step, gain} === 8'h00, "R1", "register after reset", {step, gain}, 0);
    chk(sdo_oe === 1'b0, "R1", "oe after reset", sdo_oe, 0);

    // R2 R3: every byte value written to the live address
    for (int v = 0; v < 256; v++) begin
      xfer(1'b0, LIVE, 8'(v), 8'h00, 24, got, bad);
      chk(gain === 6'(v % 64), "R3", "gain field", gain, v % 64);
      chk(step === 2'(v / 64), "R2", "step field", step, v / 64);
      chk(bad == 0, "R7", "oe during write", bad, 0);
    end

    // R5: readback of a spread of values
    for (int v = 1; v < 256; v += 9) begin
      xfer(1'b0, LIVE, 8'(v), 8'h00, 24, got, bad);
      xfer(1'b1, LIVE, 8'h00, 8'h00, 24, got, bad);
      chk(got === 8'(v), "R5", "read data", got, v);
      chk(bad == 0, "R7", "oe during read", bad, 0);
    end

    // R4 R6: every single-bit address deviation
    xfer(1'b0, LIVE, 8'hA5, 8'h00, 24, got, bad);
    for (int k = 0; k < 15; k++) begin
      xfer(1'b0, LIVE ^ (15'd1 << k), 8'h3C, 8'h00, 24, got, bad);
      chk({step, gain} === 8'hA5, "R4", "foreign write", {step, gain}, 8'hA5);
      xfer(1'b1, LIVE ^ (15'd1 << k), 8'h00, 8'h00, 24, got, bad);
      chk(got === 8'h00, "R6", "foreign read", got, 0);
      chk(bad == 0, "R7", "oe foreign read", bad, 0);
    end

    // R8: frames cut at every length
    for (int nb = 1; nb < 24; nb++) begin
      xfer(1'b0, LIVE, 8'h5A, 8'h00, nb, got, bad);
      chk({step, gain} === 8'hA5, "R8", "aborted write", {step, gain}, 8'hA5);
      chk(bad == 0, "R8", "oe aborted write", bad, 0);
    end
    xfer(1'b1, LIVE, 8'h00, 8'h00, 20, got, bad);
    chk(bad == 0, "R7", "oe aborted read", bad, 0);

    // R10: clean frame after an abort
    xfer(1'b0, LIVE, 8'h77, 8'h00, 10, got, bad);
    xfer(1'b0, LIVE, 8'hC3, 8'h00, 24, got, bad);
    chk({step, gain} === 8'hC3, "R10", "write after abort", {step, gain}, 8'hC3);

    // R9: extra clocks after the 24th bit
    xfer(1'b0, LIVE, 8'h1E, 8'hFF, 32, got, bad);
    chk({step, gain} === 8'h1E, "R9", "write with trailing bits", {step, gain}, 8'h1E);
    xfer(1'b1, LIVE, 8'h00, 8'hAA, 32, got, bad);
    chk(got === 8'h1E, "R9", "read with trailing bits", got, 8'h1E);
    chk(bad == 0, "R9", "oe with trailing bits", bad, 0);

    finish_run();
  end
endmodule